// File: doc/BRIEF.md
# IR pulse run-length sampler

This block watches the single output line of a demodulated infrared receiver and turns the waveform into a stream of run-length bytes. The receive path must be enabled before it samples. Once enabled, it looks at the line once per sample tick. A prescaler derives the tick from the base clock; by default there is one tick every 64 base-clock cycles. Each byte describes one run of constant level. The most significant bit carries the level (1 = mark, 0 = space). The lower seven bits carry the run length in ticks minus one.

Short glitches are absorbed. A stretch of the opposite level that lasts no more than a programmable noise threshold is folded into the run around it. A run longer than 128 ticks is cut into full-length chunks. A long space ends the packet: once the space has lasted (idle threshold + 1) × 128 ticks, the block raises a one-cycle packet-end pulse and drops the idle run. It then stays silent until the next mark appears. The byte strobe and the packet-end pulse are meant to feed a receive FIFO, and protocol decoding happens downstream.

Top module: `ir_runlen_sampler`

## Requirements
- R1: Sampling runs only while `glb_en` and `rx_en` are both 1 and `mode` equals 2'b11. While it runs, one sample is taken every TICK_DIV clock cycles, so a level held for N×TICK_DIV cycles counts as exactly N ticks.
- R2: `ir_in` passes through two flip-flops before it is sampled. With `inv_pol` = 1, a low input counts as mark; with `inv_pol` = 0, a high input counts as mark.
- R3: Each byte has the run level in bit 7 (1 = mark) and the run length minus one in bits 6:0. The byte for a run is emitted on the tick at which the opposite level becomes committed.
- R4: A stretch of the opposite level lasting at most `noise_thr` ticks is noise: its ticks are added to the current run and nothing is emitted. A stretch reaching `noise_thr`+1 ticks commits a new run, and that run's length starts at `noise_thr`+1.
- R5: When a run's length reaches 128 ticks, a byte with length field 127 (0x7F for space, 0xFF for mark) is emitted and counting continues with the remaining ticks at the same level. A run that is an exact multiple of 128 emits no extra byte of length zero.
- R6: After (`idle_thr`+1)×IDLE_UNIT consecutive space ticks (IDLE_UNIT = 128 by default), `pkt_end` pulses for one cycle and the current space run is discarded. No byte is emitted with it, and `byte_valid` and `pkt_end` are never high together.
- R7: After reset, after packet end and after a disable, the block is waiting: it emits nothing until a mark tick arrives. That tick starts a mark run of length 1.
- R8: Disabling the block clears the prescaler, the run length, the noise stretch and the idle count, and leaves both output strobes low from the next cycle on.
- R9: `byte_valid` and `pkt_end` are registered one-cycle pulses, both low out of reset. Each follows the cycle in which the tick occurred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ir_in | input | 1 | Raw receiver line, asynchronous |
| glb_en | input | 1 | Global enable |
| rx_en | input | 1 | Receive enable |
| mode | input | 2 | Operating mode; 2'b11 selects run-length sampling |
| inv_pol | input | 1 | 1: a low line counts as mark |
| noise_thr | input | NTHR_W (6) | Longest stretch, in ticks, treated as noise |
| idle_thr | input | ITHR_W (8) | Idle threshold in IDLE_UNIT-tick units, minus one |
| byte_valid | output | 1 | One-cycle strobe for `byte_data` |
| byte_data | output | LEN_W+1 (8) | {level, length-1} |
| pkt_end | output | 1 | One-cycle packet-end pulse |

## Verification
The bench builds the block with TICK_DIV = 4, NTHR_W = 3 and IDLE_UNIT = 16, keeping LEN_W = 7. With these values a 300-tick mark that crosses two 128-tick chunk boundaries takes about 1200 cycles. Packet end with `idle_thr` = 0 and 2 arrives after 16 and 48 space ticks, so the one-tick-short boundary can be checked next to a real packet end. Stretches of exactly `noise_thr` and `noise_thr`+1 ticks are driven to check both sides of the noise rule. A small noise field keeps the required ordering, idle unit larger than any noise stretch, while using few bits.

// File: rtl/ir_rl_pkg.sv
package ir_rl_pkg;

  typedef enum logic {
    ST_WAIT = 1'b0,
    ST_RUN  = 1'b1
  } rl_state_t;

  localparam logic [1:0] CIR_MODE = 2'b11;

  // Space ticks needed to declare the line idle.
  function automatic logic [31:0] idle_limit(input logic [31:0] thr,
                                             input logic [31:0] unit);
    return (thr + 32'd1) * unit;
  endfunction

endpackage

// File: rtl/ir_rl_sync.sv
module ir_rl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  input  logic inv,
  output logic lvl
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-2:0], d_in};
  end

  assign lvl = sh[STAGES-1] ^ inv;
endmodule

// File: rtl/ir_rl_tick.sv
module ir_rl_tick #(
  parameter int DIV = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  generate
    if (DIV == 1) begin : g_every
      assign tick = en;
    end else begin : g_count
      localparam int CNT_W = $clog2(DIV);
      localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);
      logic [CNT_W-1:0] cnt;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt <= '0;
        else if (!en)          cnt <= '0;
        else if (cnt == LAST)  cnt <= '0;
        else                   cnt <= cnt + CNT_W'(1);
      end

      assign tick = en && (cnt == LAST);

      AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R1
      AST_TICK_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !tick); // R8
    end
  endgenerate
endmodule

// File: rtl/ir_rl_runlen.sv
module ir_rl_runlen
  import ir_rl_pkg::*;
#(
  parameter int LEN_W     = 7,
  parameter int NTHR_W    = 6,
  parameter int ITHR_W    = 8,
  parameter int IDLE_UNIT = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              tick,
  input  logic              lvl,
  input  logic [NTHR_W-1:0] noise_thr,
  input  logic [ITHR_W-1:0] idle_thr,
  output logic              byte_valid,
  output logic [LEN_W:0]    byte_data,
  output logic              pkt_end
);
  localparam int RUN_MAX = 1 << LEN_W;
  localparam int CW      = LEN_W + 2;
  localparam int IW      = $clog2((1 << ITHR_W) * IDLE_UNIT) + 1;
  localparam logic [CW-1:0] RUN_MAX_C = CW'(RUN_MAX);

  rl_state_t         st;
  logic              cur_lvl;
  logic [CW-1:0]     cur_len;
  logic [NTHR_W:0]   cand_len;
  logic [IW-1:0]     idle_cnt;

  function automatic logic [LEN_W:0] pack_run(input logic l,
                                               input logic [CW-1:0] len_m1);
    return {l, len_m1[LEN_W-1:0]};
  endfunction

  // Named internal events
  logic            in_run, same, ev_start, idle_hit, ev_switch, ev_chunk;
  logic [NTHR_W:0] cand_nx;
  logic [CW-1:0]   merged;
  logic [IW-1:0]   idle_inc, idle_lim;

  assign idle_lim  = IW'(idle_limit(32'(idle_thr), 32'(IDLE_UNIT)));
  assign idle_inc  = idle_cnt + IW'(1);
  assign in_run    = tick && (st == ST_RUN);
  assign same      = (lvl == cur_lvl);
  assign ev_start  = tick && (st == ST_WAIT) && lvl;
  assign idle_hit  = in_run && !lvl && (idle_inc == idle_lim);
  assign cand_nx   = cand_len + (NTHR_W+1)'(1);
  assign merged    = cur_len + CW'(cand_len) + CW'(1);
  assign ev_switch = in_run && !idle_hit && !same && (cand_nx > {1'b0, noise_thr});
  assign ev_chunk  = in_run && !idle_hit && same && (merged >= RUN_MAX_C);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_WAIT;
      cur_lvl    <= 1'b0;
      cur_len    <= '0;
      cand_len   <= '0;
      idle_cnt   <= '0;
      byte_valid <= 1'b0;
      byte_data  <= '0;
      pkt_end    <= 1'b0;
    end else if (!en) begin
      st         <= ST_WAIT;
      cur_len    <= '0;
      cand_len   <= '0;
      idle_cnt   <= '0;
      byte_valid <= 1'b0;
      pkt_end    <= 1'b0;
    end else begin
      byte_valid <= 1'b0;
      pkt_end    <= 1'b0;
      if (ev_start) begin
        st       <= ST_RUN;
        cur_lvl  <= 1'b1;
        cur_len  <= CW'(1);
        cand_len <= '0;
        idle_cnt <= '0;
      end else if (in_run) begin
        idle_cnt <= lvl ? '0 : idle_inc;
        if (idle_hit) begin
          pkt_end  <= 1'b1;
          st       <= ST_WAIT;
          cur_len  <= '0;
          cand_len <= '0;
          idle_cnt <= '0;
        end else if (same) begin
          cand_len <= '0;
          if (ev_chunk) begin
            byte_valid <= 1'b1;
            byte_data  <= pack_run(cur_lvl, RUN_MAX_C - CW'(1));
            cur_len    <= merged - RUN_MAX_C;
          end else begin
            cur_len <= merged;
          end
        end else if (ev_switch) begin
          if (cur_len != '0) begin
            byte_valid <= 1'b1;
            byte_data  <= pack_run(cur_lvl, cur_len - CW'(1));
          end
          cur_lvl  <= lvl;
          cur_len  <= CW'(cand_nx);
          cand_len <= '0;
        end else begin
          cand_len <= cand_nx;
        end
      end
    end
  end

  AST_BYTE_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> $past(tick)); // R9
  AST_PKT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_end |=> !pkt_end); // R6
  AST_PKT_NO_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    !(byte_valid && pkt_end)); // R6
  AST_WAIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT) |=> !byte_valid); // R7
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!byte_valid && !pkt_end)); // R8
  AST_CHUNK_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    ev_chunk |=> (byte_valid && (byte_data[LEN_W-1:0] == {LEN_W{1'b1}}))); // R5
  AST_SWITCH_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_switch && (cur_len != '0)) |=> (byte_valid && (byte_data[LEN_W] != cur_lvl))); // R3
endmodule

// File: rtl/ir_runlen_sampler.sv
module ir_runlen_sampler
  import ir_rl_pkg::*;
#(
  parameter int TICK_DIV  = 64,
  parameter int LEN_W     = 7,
  parameter int NTHR_W    = 6,
  parameter int ITHR_W    = 8,
  parameter int IDLE_UNIT = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ir_in,
  input  logic              glb_en,
  input  logic              rx_en,
  input  logic [1:0]        mode,
  input  logic              inv_pol,
  input  logic [NTHR_W-1:0] noise_thr,
  input  logic [ITHR_W-1:0] idle_thr,
  output logic              byte_valid,
  output logic [LEN_W:0]    byte_data,
  output logic              pkt_end
);
  logic en, tick, lvl;

  assign en = glb_en && rx_en && (mode == CIR_MODE);

  ir_rl_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in(ir_in), .inv(inv_pol), .lvl(lvl)
  );

  ir_rl_tick #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .en(en), .tick(tick)
  );

  ir_rl_runlen #(
    .LEN_W(LEN_W), .NTHR_W(NTHR_W), .ITHR_W(ITHR_W), .IDLE_UNIT(IDLE_UNIT)
  ) u_run (
    .clk(clk), .rst_n(rst_n), .en(en), .tick(tick), .lvl(lvl),
    .noise_thr(noise_thr), .idle_thr(idle_thr),
    .byte_valid(byte_valid), .byte_data(byte_data), .pkt_end(pkt_end)
  );
endmodule

// File: tb/sim_ir_runlen_sampler.sv
`timescale 1ns/1ps
module sim_ir_runlen_sampler;
  localparam int DIV = 4, LEN_W = 7, NTHR_W = 3, ITHR_W = 8, UNIT = 16;

  logic clk = 0, rst_n = 0, ir_in = 1, glb_en = 0, rx_en = 0, inv_pol = 1;
  logic [1:0] mode = 2'b11;
  logic [NTHR_W-1:0] noise_thr = 1;
  logic [ITHR_W-1:0] idle_thr = 0;
  logic byte_valid, pkt_end;
  logic [LEN_W:0] byte_data;

  always #2.5 clk = ~clk;

  ir_runlen_sampler #(.TICK_DIV(DIV), .LEN_W(LEN_W), .NTHR_W(NTHR_W),
    .ITHR_W(ITHR_W), .IDLE_UNIT(UNIT)) u0 (
    .clk(clk), .rst_n(rst_n), .ir_in(ir_in), .glb_en(glb_en), .rx_en(rx_en),
    .mode(mode), .inv_pol(inv_pol), .noise_thr(noise_thr), .idle_thr(idle_thr),
    .byte_valid(byte_valid), .byte_data(byte_data), .pkt_end(pkt_end));

  int n_cmp = 0, n_bad = 0;
  string phase = "R9 reset";
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Behavioural reference model
  int mf1 = 0, mf2 = 0, mcnt = 0, mst = 0, mlvl = 0, mlen = 0, mcand = 0, midle = 0;
  int e_bv = 0, e_pe = 0, e_data = 0;
  always @(posedge clk) begin
    int lv, tk, en;
    if (!rst_n) begin
      mf1 = 0; mf2 = 0; mcnt = 0; mst = 0; mlen = 0; mcand = 0; midle = 0;
      e_bv = 0; e_pe = 0; mlvl = 0;
    end else begin
      en = (glb_en && rx_en && mode == 2'b11) ? 1 : 0;
      lv = mf2 ^ int'(inv_pol);
      tk = (en == 1 && mcnt == DIV - 1) ? 1 : 0;
      e_bv = 0; e_pe = 0;
      if (en == 0) begin
        mcnt = 0; mst = 0; mlen = 0; mcand = 0; midle = 0;
      end else begin
        mcnt = (mcnt == DIV - 1) ? 0 : mcnt + 1;
        if (tk == 1) begin
          if (mst == 0) begin
            if (lv == 1) begin mst = 1; mlvl = 1; mlen = 1; mcand = 0; midle = 0; end
          end else begin
            midle = (lv == 0) ? midle + 1 : 0;
            if (lv == 0 && midle == (int'(idle_thr) + 1) * UNIT) begin
              e_pe = 1; mst = 0; mlen = 0; mcand = 0; midle = 0;
            end else if (lv == mlvl) begin
              mlen = mlen + mcand + 1; mcand = 0;
              if (mlen >= 128) begin e_bv = 1; e_data = mlvl * 128 + 127; mlen -= 128; end
            end else begin
              mcand++;
              if (mcand > int'(noise_thr)) begin
                if (mlen > 0) begin e_bv = 1; e_data = mlvl * 128 + mlen - 1; end
                mlvl = lv; mlen = mcand; mcand = 0;
              end
            end
          end
        end
      end
      mf2 = mf1; mf1 = int'(ir_in);
    end
  end

  // Per-cycle comparison and capture
  logic [7:0] got[$];
  int pkts = 0;
  always @(negedge clk) if (rst_n && !done) begin
    chk(int'(byte_valid) == e_bv, {phase, " byte_valid"}, byte_valid, e_bv);
    chk(int'(pkt_end) == e_pe, {phase, " pkt_end"}, pkt_end, e_pe);
    if (byte_valid && e_bv == 1)
      chk(int'(byte_data) == e_data, {phase, " byte_data"}, byte_data, e_data);
    if (byte_valid) got.push_back(byte_data);
    if (pkt_end) pkts++;
  end

  // mark = 1 means the line carries a mark under the present polarity
  task automatic seg(input bit mark, input int ticks);
    ir_in = mark ^ inv_pol;
    repeat (ticks * DIV) @(negedge clk);
  endtask

  task automatic expect_list(input string tag, input logic [7:0] exp[$], input int exp_pk);
    repeat (12) @(negedge clk);
    chk(got.size() == exp.size(), {tag, " byte count"}, got.size(), exp.size());
    foreach (exp[i]) if (i < got.size())
      chk(got[i] == exp[i], {tag, " byte"}, got[i], exp[i]);
    chk(pkts == exp_pk, {tag, " packet ends"}, pkts, exp_pk);
    got.delete(); pkts = 0;
  endtask

  initial begin
    #200000000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual=0 expected=1");
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(byte_valid == 0 && pkt_end == 0, "R9 reset outputs", {byte_valid, pkt_end}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(byte_valid == 0 && pkt_end == 0, "R9 after reset", {byte_valid, pkt_end}, 0);
    glb_en = 1; rx_en = 1;

    phase = "R1 R3 R7 basic runs";
    seg(0, 20); seg(1, 10); seg(0, 5); seg(1, 3); seg(0, 20);
    expect_list("R1 R3 R7 basic runs", '{8'h89, 8'h04, 8'h82}, 1);

    phase = "R4 noise merge";
    noise_thr = 2;
    seg(1, 6); seg(0, 2); seg(1, 4); seg(0, 3); seg(1, 5); seg(0, 20);
    expect_list("R4 noise merge", '{8'h8B, 8'h02, 8'h84}, 1);

    phase = "R5 long mark chunks";
    noise_thr = 1;
    seg(1, 300); seg(0, 20);
    expect_list("R5 long mark chunks", '{8'hFF, 8'hFF, 8'hAB}, 1);

    phase = "R5 exact 256";
    seg(1, 256); seg(0, 20);
    expect_list("R5 exact 256", '{8'hFF, 8'hFF}, 1);

    phase = "R2 polarity";
    inv_pol = 0; ir_in = 0;
    seg(0, 4); seg(1, 7); seg(0, 20);
    expect_list("R2 polarity", '{8'h86}, 1);
    inv_pol = 1; ir_in = 1;
    seg(0, 4);

    phase = "R6 idle boundary";
    idle_thr = 2;
    seg(1, 4); seg(0, 47); seg(1, 4); seg(0, 60);
    expect_list("R6 idle boundary", '{8'h83, 8'h2E, 8'h83}, 1);
    idle_thr = 0;

    phase = "R8 disable";
    seg(1, 10);
    rx_en = 0;
    seg(1, 5);
    chk(byte_valid == 0 && pkt_end == 0, "R8 quiet while off", {byte_valid, pkt_end}, 0);
    rx_en = 1;
    seg(0, 30);
    expect_list("R8 R7 disable then space", '{}, 0);

    phase = "R1 mode gate";
    mode = 2'b01;
    seg(1, 10); seg(0, 30);
    expect_list("R1 wrong mode", '{}, 0);
    mode = 2'b11;
    seg(1, 9); seg(0, 20);
    expect_list("R1 mode restored", '{8'h88}, 1);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule